// File: doc/BRIEF.md
# Serial-in shift-and-store register

The block turns a serial bit stream into a parallel byte whose outputs stay stable while the next byte is being shifted in. A chain of flip-flop stages takes one serial bit on every rising edge of the clock. A separate storage register holds the byte that drives the parallel outputs. That register is reloaded only when the strobe input falls, and at that moment it copies the whole chain.

The parallel outputs are three-state. With the output enable high they show the stored byte. With it low they float, and the stored byte is kept.

The last chain stage leaves the block as a true and complement pair. Several instances can therefore be chained to build a wider output port: the true output of one instance feeds the serial input of the next. The strobe is sampled in the clock domain, so a transfer takes effect on the clock edge at which the strobe is first seen low after being seen high.

Top module: `shift_store_reg`

## Requirements
- R1: While `rst_ni` is low, every chain stage, every storage bit and the sampled strobe are cleared to 0. With `oe_i` high the parallel outputs then read 0.
- R2: On each rising clock edge, stage 1 takes `ser_i` and each stage k>1 takes the old value of stage k-1.
- R3: After eight consecutive edges, the bit presented first is in stage 8. Stage k (1..8) maps to `par_o[k-1]`, so the first bit lands on `par_o[7]`.
- R4: A transfer fires on an edge where the strobe sampled at the previous edge was 1 and `strobe_i` is now 0. The storage register then takes the chain contents as they were before that edge's shift.
- R5: On every other edge the storage register holds its value. This covers shifting with the strobe steady high or low, and a strobe rise.
- R6: With `oe_i` high, `par_o` equals the stored byte.
- R7: With `oe_i` low, all bits of `par_o` are high-impedance and none is driven to 1.
- R8: Lowering and raising `oe_i` leaves the stored byte intact, and the same byte reappears on `par_o`.
- R9: `qs_o` equals stage 8 and `qs_n_o` is its complement at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shift clock; all state changes on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_i | input | 1 | Serial data into stage 1 |
| strobe_i | input | 1 | Transfer control; a sampled high-to-low step loads storage |
| oe_i | input | 1 | Parallel output enable, active high |
| par_o | output | STAGES | Stored byte, or high-impedance when disabled |
| qs_o | output | 1 | Last chain stage, for cascading |
| qs_n_o | output | 1 | Complement of the last chain stage |

## Verification
The bench builds the block with the default of eight stages. With that value, a full byte fits in the chain in eight edges, and the first-in bit can be checked against the highest output. The tests then cover a strobe fall that coincides with a shift edge, and output-enable toggling on a byte whose bits are both 0 and 1, so a missing gate is visible on the outputs.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  parameter int unsigned SSR_DEF_STAGES = 8;
endpackage

// File: rtl/ssr_shift_chain.sv
module ssr_shift_chain #(
  parameter int unsigned N = ssr_pkg::SSR_DEF_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ser_i,
  output logic [N-1:0] stg_o
);
  logic [N:0] link;
  assign link[0] = ser_i;

  for (genvar k = 0; k < N; k++) begin : g_stage
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= 1'b0;
      else         bit_q <= link[k];
    end
    assign link[k+1] = bit_q;
    assign stg_o[k]  = bit_q;
  end
endmodule

// File: rtl/ssr_strobe_det.sv
module ssr_strobe_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic prev_o,
  output logic fall_o
);
  logic prev_q;
  // reset to 0 so a strobe held low across reset release loads nothing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= strobe_i;
  end
  assign prev_o = prev_q;
  assign fall_o = prev_q & ~strobe_i;
endmodule

// File: rtl/ssr_store.sv
module ssr_store #(
  parameter int unsigned N = ssr_pkg::SSR_DEF_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (load_i) q_q <= d_i;
  end
  assign q_o = q_q;
endmodule

// File: rtl/shift_store_reg.sv
module shift_store_reg #(
  parameter int unsigned STAGES = ssr_pkg::SSR_DEF_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_i,
  input  logic              strobe_i,
  input  logic              oe_i,
  output logic [STAGES-1:0] par_o,
  output logic              qs_o,
  output logic              qs_n_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] st_q;
  logic              strb_q;
  logic              xfer;
  logic [STAGES-1:0] drv_data;
  logic              drv_en;

  ssr_shift_chain #(.N(STAGES)) u_chain (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ser_i (ser_i),
    .stg_o (sh_q)
  );

  ssr_strobe_det u_strb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe_i),
    .prev_o  (strb_q),
    .fall_o  (xfer)
  );

  // load uses pre-shift chain value: same edge as the shift
  ssr_store #(.N(STAGES)) u_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(xfer),
    .d_i   (sh_q),
    .q_o   (st_q)
  );

  assign drv_data = st_q;
  assign drv_en   = oe_i;

  // only place the bus floats
  assign par_o  = drv_en ? drv_data : {STAGES{1'bz}};
  assign qs_o   = sh_q[LAST];
  assign qs_n_o = ~sh_q[LAST];
endmodule

// File: rtl/shift_store_reg_chk.sv
module shift_store_reg_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         ser_i,
  input logic         strobe_i,
  input logic         oe_i,
  input logic [N-1:0] par_o,
  input logic         qs_o,
  input logic         qs_n_o,
  input logic [N-1:0] sh_q,
  input logic [N-1:0] st_q,
  input logic         strb_q
);
  // R2
  shift_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> sh_q == {$past(sh_q[N-2:0]), $past(ser_i)});

  // R4
  xfer_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strb_q && !strobe_i) |=> st_q == $past(sh_q));

  // R5
  store_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strb_q && !strobe_i) |=> $stable(st_q));

  // R6
  oe_show_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |-> par_o == st_q);

  // R9
  casc_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qs_o == sh_q[N-1]) && (qs_n_o != qs_o));
endmodule

bind shift_store_reg shift_store_reg_chk #(.N(STAGES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ser_i   (ser_i),
  .strobe_i(strobe_i),
  .oe_i    (oe_i),
  .par_o   (par_o),
  .qs_o    (qs_o),
  .qs_n_o  (qs_n_o),
  .sh_q    (sh_q),
  .st_q    (st_q),
  .strb_q  (strb_q)
);

// File: tb/shift_store_reg_tb_top.sv
module shift_store_reg_tb_top;
  localparam int unsigned N = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         ser_i = 1'b0;
  logic         strobe_i = 1'b1;
  logic         oe_i = 1'b1;
  logic [N-1:0] par_o;
  logic         qs_o;
  logic         qs_n_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [N-1:0] m_sh = '0;
  logic [N-1:0] m_st = '0;
  logic         m_prev = 1'b0;

  always #5 clk_i = ~clk_i;

  shift_store_reg #(.STAGES(N)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ser_i(ser_i), .strobe_i(strobe_i),
    .oe_i(oe_i), .par_o(par_o), .qs_o(qs_o), .qs_n_o(qs_n_o)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one clock edge, reference model updated from requirements
  task automatic step();
    @(posedge clk_i);
    if (m_prev && !strobe_i) m_st = m_sh;
    m_sh   = {m_sh[N-2:0], ser_i};
    m_prev = strobe_i;
    @(negedge clk_i);
  endtask

  task automatic load_byte(input logic [N-1:0] b);
    for (int i = N - 1; i >= 0; i--) begin
      ser_i = b[i];
      step();
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; oe_i = 1'b1; strobe_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 par after reset", par_o, '0);
    chk("R1 qs after reset", {7'd0, qs_o}, '0);
    rst_ni = 1'b1;
    m_sh = '0; m_st = '0; m_prev = 1'b0;
  endtask

  task automatic t_load_xfer(input logic [N-1:0] b);
    strobe_i = 1'b1;
    load_byte(b);
    chk("R5 no xfer while strobe high", par_o, m_st);
    chk("R3 qs holds first bit", {7'd0, qs_o}, {7'd0, b[N-1]});
    strobe_i = 1'b0;
    ser_i = ~b[0];
    step();  // shift and transfer on the same edge
    chk("R4 xfer takes pre-shift byte", par_o, b);
    chk("R4 model agrees", par_o, m_st);
  endtask

  task automatic t_hold_low();
    logic [N-1:0] keep;
    keep = m_st;
    load_byte(8'h3C);
    chk("R5 strobe low steady", par_o, keep);
    strobe_i = 1'b1;
    step();
    chk("R5 strobe rise no xfer", par_o, keep);
    load_byte(8'h96);
    chk("R5 strobe high steady", par_o, keep);
  endtask

  task automatic t_oe();
    logic hi;
    oe_i = 1'b0;
    #1;
    hi = 1'b0;
    for (int b = 0; b < N; b++) if (par_o[b] === 1'b1) hi = 1'b1;
    chk("R7 disabled drives no 1", {7'd0, hi}, '0);
    step();
    step();
    oe_i = 1'b1;
    #1;
    chk("R8 byte reappears", par_o, m_st);
  endtask

  task automatic t_cascade();
    for (int i = 0; i < 12; i++) begin
      ser_i = i[0] ^ i[2];
      step();
      chk("R9 qs is stage 8", {7'd0, qs_o}, {7'd0, m_sh[N-1]});
      chk("R9 qs_n complement", {7'd0, qs_n_o}, {7'd0, ~m_sh[N-1]});
    end
  endtask

  task automatic t_shift_single();
    strobe_i = 1'b1;
    load_byte(8'h00);
    ser_i = 1'b1;
    step();
    ser_i = 1'b0;
    strobe_i = 1'b0;
    step();
    chk("R2 single one in stage 1", par_o, 8'h01);
  endtask

  initial begin
    fork
      begin
        @(negedge clk_i);
        t_reset();
        t_load_xfer(8'hA5);
        t_oe();
        t_load_xfer(8'h81);
        t_hold_low();
        t_shift_single();
        strobe_i = 1'b1;
        step();
        t_load_xfer(8'h5A);
        t_cascade();
      end
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule